// File: doc/BRIEF.md
# Decimal-Adjusting Carry-Select Adder

This block is a purely combinational add/subtract unit for an 8-bit accumulator-style ALU. It works in binary or packed-BCD arithmetic. The operand width is built from 4-bit digits. Each digit has two raw adders that work side by side on the same operands. One adder has its carry input tied low and the other tied high. The carry that actually arrives at the digit then picks one of the two results through a 2:1 select, and picks the digit's carry-out the same way.

In decimal mode the unit decides whether a digit needs correction, and forms the corrected digit, from the carry-in-low sum and its carry only, together with the carry arriving at the digit. The correction never waits for the selected sum, so the time-critical path stays on the carry select. To make up for the missing carry, the test thresholds move with the incoming carry: an addition digit is corrected above 9 or above 8, and a subtraction digit reads a low sum of $F as carrying out. The incoming carry is then added back into the digit. Subtraction is A plus the ones' complement of B plus the carry input, so a carry input of 1 means there is no pending borrow.

Top module: `bcd_csel_alu`

## Requirements
- R1: With dec_i=0 and sub_i=0, {carry_o, sum_o} equals a_i + b_i + carry_i as an unsigned binary sum one bit wider than the operands.
- R2: With dec_i=0 and sub_i=1, {carry_o, sum_o} equals a_i + ~b_i + carry_i, so carry_o=1 means no borrow and carry_i=1 means none was pending.
- R3: With dec_i=1, sub_i=0 and both operands valid packed BCD (each 4-bit digit, least significant digit in bits 3:0, in 0..9), sum_o is the BCD code of (A+B+carry_i) mod 100 and carry_o is 1 exactly when A+B+carry_i is at least 100.
- R4: With dec_i=1, sub_i=1 and valid BCD operands, sum_o is the BCD code of (A-B-(1-carry_i)) mod 100 and carry_o is 1 exactly when that difference is not negative.
- R5: In decimal addition a digit whose carry-in-low sum is 9 is corrected when the incoming carry is 1, so 09+00 with carry_i=1 gives 10 with carry_o=0, and 99+00 with carry_i=1 gives 00 with carry_o=1.
- R6: In decimal subtraction a digit whose carry-in-low sum is $F counts as carrying out when its incoming carry is 1, so 05-05 with carry_i=1 gives 00 with carry_o=1, and 10-00 with carry_i=0 gives 09 with carry_o=1.
- R7: In decimal mode with valid BCD operands every digit of sum_o is in 0..9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4*DIGITS | First operand |
| b_i | input | 4*DIGITS | Second operand (subtrahend when sub_i=1) |
| carry_i | input | 1 | Carry in; for subtraction 1 means no borrow |
| sub_i | input | 1 | 1 selects subtraction |
| dec_i | input | 1 | 1 selects packed-BCD arithmetic |
| sum_o | output | 4*DIGITS | Result |
| carry_o | output | 1 | Carry out; for subtraction 1 means no borrow |

## Verification
The bench builds the unit with DIGITS=2, the 8-bit width it is meant for. At that width the whole input space can be swept. Every binary operand pair is applied with both carry values in both add and subtract. Every pair of valid two-digit BCD operands is applied with both carries and both operations and compared with plain decimal arithmetic. This covers each threshold corner: the above-8 and $F cases, decimal carries that ripple from the low digit to the high digit, and wrap-around past 99 and below 00.

// File: rtl/bcd_csel_pkg.sv
package bcd_csel_pkg;
    localparam int NIB_W = 4;

    // Both raw sums of one digit, computed ahead of the incoming carry
    typedef struct packed {
        logic [NIB_W-1:0] s_lo;
        logic             c_lo;
        logic [NIB_W-1:0] s_hi;
        logic             c_hi;
    } raw_pair_t;

    // Digit result after selection and optional decimal correction
    typedef struct packed {
        logic [NIB_W-1:0] val;
        logic             cy;
    } digit_res_t;
endpackage

// File: rtl/bcd_csel_pair.sv
module bcd_csel_pair
    import bcd_csel_pkg::*;
(
    input  logic [NIB_W-1:0] a_i,
    input  logic [NIB_W-1:0] b_i,
    output raw_pair_t        raw_o
);
    logic [NIB_W:0] lo_d;
    logic [NIB_W:0] hi_d;

    always_comb begin
        lo_d = {1'b0, a_i} + {1'b0, b_i};
        hi_d = {1'b0, a_i} + {1'b0, b_i} + (NIB_W+1)'(1);
        raw_o.s_lo = lo_d[NIB_W-1:0];
        raw_o.c_lo = lo_d[NIB_W];
        raw_o.s_hi = hi_d[NIB_W-1:0];
        raw_o.c_hi = hi_d[NIB_W];
    end
endmodule

// File: rtl/bcd_csel_digit.sv
module bcd_csel_digit
    import bcd_csel_pkg::*;
(
    input  raw_pair_t  raw_i,
    input  logic       ci_i,
    input  logic       sub_i,
    input  logic       dec_i,
    output digit_res_t res_o
);
    localparam logic [NIB_W-1:0] ADD_ADJ = NIB_W'(6);
    localparam logic [NIB_W-1:0] SUB_ADJ = NIB_W'(10);

    logic             add_fix_d;
    logic             sub_cy_d;
    logic [NIB_W-1:0] base_d;

    always_comb begin
        // thresholds shift with the carry the low sum never saw
        add_fix_d = raw_i.c_lo
                  | (!ci_i && (raw_i.s_lo > NIB_W'(9)))
                  | ( ci_i && (raw_i.s_lo > NIB_W'(8)));
        sub_cy_d  = raw_i.c_lo | (ci_i && (raw_i.s_lo == {NIB_W{1'b1}}));
        base_d    = raw_i.s_lo + NIB_W'(ci_i);

        if (!dec_i) begin
            res_o.val = ci_i ? raw_i.s_hi : raw_i.s_lo;
            res_o.cy  = ci_i ? raw_i.c_hi : raw_i.c_lo;
        end else if (!sub_i) begin
            res_o.val = base_d + (add_fix_d ? ADD_ADJ : '0);
            res_o.cy  = add_fix_d;
        end else begin
            res_o.val = base_d + (sub_cy_d ? '0 : SUB_ADJ);
            res_o.cy  = sub_cy_d;
        end
    end
endmodule

// File: rtl/bcd_csel_alu.sv
module bcd_csel_alu
    import bcd_csel_pkg::*;
#(
    parameter int DIGITS = 2
) (
    input  logic [NIB_W*DIGITS-1:0] a_i,
    input  logic [NIB_W*DIGITS-1:0] b_i,
    input  logic                    carry_i,
    input  logic                    sub_i,
    input  logic                    dec_i,
    output logic [NIB_W*DIGITS-1:0] sum_o,
    output logic                    carry_o
);
    localparam int W = NIB_W * DIGITS;

    logic [W-1:0]     b_eff_d;
    logic [DIGITS:0]  chain_d;
    logic [W-1:0]     sum_d;

    assign b_eff_d    = sub_i ? ~b_i : b_i;
    assign chain_d[0] = carry_i;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        raw_pair_t  raw_d;
        digit_res_t res_d;

        bcd_csel_pair u_pair (
            .a_i   (a_i[g*NIB_W +: NIB_W]),
            .b_i   (b_eff_d[g*NIB_W +: NIB_W]),
            .raw_o (raw_d)
        );

        bcd_csel_digit u_fix (
            .raw_i (raw_d),
            .ci_i  (chain_d[g]),
            .sub_i (sub_i),
            .dec_i (dec_i),
            .res_o (res_d)
        );

        assign sum_d[g*NIB_W +: NIB_W] = res_d.val;
        assign chain_d[g+1]            = res_d.cy;
    end

    assign sum_o   = sum_d;
    assign carry_o = chain_d[DIGITS];
endmodule

// File: rtl/bcd_csel_alu_chk.sv
module bcd_csel_alu_chk
    import bcd_csel_pkg::*;
#(
    parameter int DIGITS = 2
) (
    input logic [NIB_W*DIGITS-1:0] a_i,
    input logic [NIB_W*DIGITS-1:0] b_i,
    input logic                    carry_i,
    input logic                    sub_i,
    input logic                    dec_i,
    input logic [NIB_W*DIGITS-1:0] sum_o,
    input logic                    carry_o
);
    localparam int W = NIB_W * DIGITS;

    function automatic int modulus();
        int m = 1;
        for (int i = 0; i < DIGITS; i++) m = m * 10;
        return m;
    endfunction

    function automatic logic is_bcd(logic [W-1:0] x);
        logic ok = 1'b1;
        for (int i = 0; i < DIGITS; i++)
            if (x[i*NIB_W +: NIB_W] > NIB_W'(9)) ok = 1'b0;
        return ok;
    endfunction

    function automatic int dec_of(logic [W-1:0] x);
        int v = 0;
        for (int i = DIGITS-1; i >= 0; i--)
            v = v * 10 + int'(x[i*NIB_W +: NIB_W]);
        return v;
    endfunction

    logic ops_ok;
    int   add_tot;
    int   sub_tot;
    assign ops_ok  = is_bcd(a_i) && is_bcd(b_i);
    assign add_tot = dec_of(a_i) + dec_of(b_i) + int'(carry_i);
    assign sub_tot = dec_of(a_i) - dec_of(b_i) - int'(!carry_i);

    always_comb begin
        if (!dec_i && !sub_i)
            // R1
            bin_add_chk: assert ({carry_o, sum_o} ==
                                 ({1'b0, a_i} + {1'b0, b_i} + (W+1)'(carry_i)));
        if (!dec_i && sub_i)
            // R2
            bin_sub_chk: assert ({carry_o, sum_o} ==
                                 ({1'b0, a_i} + {1'b0, ~b_i} + (W+1)'(carry_i)));
        if (dec_i && !sub_i && ops_ok)
            // R3
            dec_add_cy_chk: assert (carry_o == (add_tot >= modulus()));
        if (dec_i && sub_i && ops_ok)
            // R4
            dec_sub_cy_chk: assert (carry_o == (sub_tot >= 0));
        if (dec_i && ops_ok)
            // R7
            digit_range_chk: assert (is_bcd(sum_o));
    end
endmodule

bind bcd_csel_alu bcd_csel_alu_chk #(.DIGITS(DIGITS)) u_chk (
    .a_i     (a_i),
    .b_i     (b_i),
    .carry_i (carry_i),
    .sub_i   (sub_i),
    .dec_i   (dec_i),
    .sum_o   (sum_o),
    .carry_o (carry_o)
);

// File: tb/sim_bcd_csel_alu.sv
module sim_bcd_csel_alu;
    localparam int DIG = 2;
    localparam int W   = 4 * DIG;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [W-1:0] a, b, sum;
    logic         cin, sub, dec, cout;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    bcd_csel_alu #(.DIGITS(DIG)) u0 (
        .a_i(a), .b_i(b), .carry_i(cin), .sub_i(sub), .dec_i(dec),
        .sum_o(sum), .carry_o(cout)
    );

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else begin
            cyc <= cyc + 1;
            if (cyc > WATCHDOG && !done) begin
                fails  = fails + 1;
                checks = checks + 1;
                $display("FAIL watchdog: actual cycles=%0d expected <=%0d", cyc, WATCHDOG);
                summary();
                $finish;
            end
        end
    end

    function automatic logic [W-1:0] to_bcd(int v);
        return W'(((v / 10) << 4) | (v % 10));
    endfunction

    task automatic chk(string req, logic [W:0] act, logic [W:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: a=%h b=%h cin=%0d sub=%0d dec=%0d actual=%h expected=%h",
                     req, a, b, cin, sub, dec, act, exp);
        end
    endtask

    task automatic apply(logic [W-1:0] av, logic [W-1:0] bv, logic c, logic s, logic d);
        a = av; b = bv; cin = c; sub = s; dec = d;
        #1;
    endtask

    // R1: all zero inputs give all zero outputs
    task automatic t_quiet();
        apply('0, '0, 1'b0, 1'b0, 1'b0);
        chk("R1 quiet", {cout, sum}, '0);
    endtask

    task automatic t_bin_add();   // R1
        for (int x = 0; x < 256; x++)
            for (int y = 0; y < 256; y++)
                for (int c = 0; c < 2; c++) begin
                    apply(W'(x), W'(y), 1'(c), 1'b0, 1'b0);
                    chk("R1", {cout, sum}, (W+1)'(x + y + c));
                end
    endtask

    task automatic t_bin_sub();   // R2
        for (int x = 0; x < 256; x++)
            for (int y = 0; y < 256; y++)
                for (int c = 0; c < 2; c++) begin
                    apply(W'(x), W'(y), 1'(c), 1'b1, 1'b0);
                    chk("R2", {cout, sum}, (W+1)'(x + (255 - y) + c));
                end
    endtask

    task automatic t_dec_add();   // R3, R7
        for (int x = 0; x < 100; x++)
            for (int y = 0; y < 100; y++)
                for (int c = 0; c < 2; c++) begin
                    int t = x + y + c;
                    apply(to_bcd(x), to_bcd(y), 1'(c), 1'b0, 1'b1);
                    chk("R3/R7", {cout, sum}, {1'(t >= 100), to_bcd(t % 100)});
                end
    endtask

    task automatic t_dec_sub();   // R4, R7
        for (int x = 0; x < 100; x++)
            for (int y = 0; y < 100; y++)
                for (int c = 0; c < 2; c++) begin
                    int t = x - y - (1 - c);
                    apply(to_bcd(x), to_bcd(y), 1'(c), 1'b1, 1'b1);
                    chk("R4/R7", {cout, sum}, {1'(t >= 0), to_bcd((t + 100) % 100)});
                end
    endtask

    task automatic t_corners();
        // R5: carry-in-low sum of 9 with incoming carry 1
        apply(8'h09, 8'h00, 1'b1, 1'b0, 1'b1);
        chk("R5 09+00+1", {cout, sum}, {1'b0, 8'h10});
        apply(8'h99, 8'h00, 1'b1, 1'b0, 1'b1);
        chk("R5 99+00+1", {cout, sum}, {1'b1, 8'h00});
        // R6: carry-in-low sum of $F
        apply(8'h05, 8'h05, 1'b1, 1'b1, 1'b1);
        chk("R6 05-05", {cout, sum}, {1'b1, 8'h00});
        apply(8'h10, 8'h00, 1'b0, 1'b1, 1'b1);
        chk("R6 10-00-1", {cout, sum}, {1'b1, 8'h09});
        apply(8'h00, 8'h00, 1'b0, 1'b1, 1'b1);
        chk("R6 00-00-1", {cout, sum}, {1'b0, 8'h99});
    endtask

    initial begin
        a = '0; b = '0; cin = 1'b0; sub = 1'b0; dec = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_quiet();
        t_corners();
        t_bin_add();
        t_bin_sub();
        t_dec_add();
        t_dec_sub();
        done = 1'b1;
        summary();
        $finish;
    end
endmodule